// File: doc/BRIEF.md
# Expansion-Card Bus Slave with Wait-State Stretching

This block is the bus-facing front end of an expansion card on a legacy PC-style synchronous bus. It watches a 24-bit address and four active-low strobes: memory read, memory write, I/O read and I/O write. When exactly one strobe is low and the address falls inside the card's window for that space, the block claims the cycle. Reads come from a small internal register file and writes go into it, over a 16-bit data path. Memory space and I/O space each have their own base-address parameter. Both windows alias the same registers.

The internal side is taken to be slow. After it claims a cycle, the block raises a wait request for a fixed, parameterised number of clocks, from 0 to 3. This stretches the cycle, which would otherwise have a fixed length. The block enables its read data onto the shared bus only during its own read cycles, and withdraws the enable one clock after the strobe goes away. Cycles with more than one strobe low at once are ignored.

A four-state controller sequences each cycle:
- `ST_IDLE` moves to `ST_STRETCH` when a cycle is claimed, or straight to `ST_SERVE` when the wait count is zero.
- `ST_STRETCH` counts the wait clocks down and moves to `ST_SERVE` when the count runs out.
- `ST_SERVE` does one of two things. On a write it commits the data and moves to `ST_HOLD`. On a read it stays in `ST_SERVE` and keeps driving.
- `ST_HOLD` waits for the strobe to rise.

Every non-idle state falls back to `ST_IDLE` in the clock after the cycle's strobe is seen high, or after a second strobe is seen low.

Top module: `expbus_slave`

## Requirements
- R1: After reset, `wait_req` and `data_oe` are 0 and every register reads back as 0.
- R2: A memory strobe (`memr_n` or `memw_n`) is claimed when `addr[23:IDXW]` equals `MEM_BASE[23:IDXW]`. Register index = `addr[IDXW-1:0]`, with IDXW = log2(NREG) = 3 by default.
- R3: An I/O strobe (`ior_n` or `iow_n`) is claimed when `addr[15:IDXW]` equals `IO_BASE[15:IDXW]`. Address bits 23:16 are ignored for I/O.
- R4: Both windows address the same registers. Data written through one space reads back through the other at the same index.
- R5: In a claimed cycle, `wait_req` is high for exactly WAITS consecutive clocks, starting at the clock edge where the strobe is first sampled low. An unclaimed cycle never raises it.
- R6: A claimed write stores `data_in` at the first edge where the strobe is still low and the wait period has ended. It stores exactly once per cycle.
- R7: In a claimed read, `data_oe` goes high at the edge that samples the strobe low. It stays high up to and including the clock in which the strobe rises, and falls at the next edge. While the wait period has ended and `data_oe` is high, `data_out` shows the addressed register.
- R8: `data_oe` is never high during a write cycle or an unclaimed cycle. When it is low, `data_out` is 0.
- R9: When more than one strobe is low at once, the cycle is ignored. If a second strobe falls during a claimed cycle, that cycle is abandoned without a write, and the controller is idle at the next edge.
- R10: If a write strobe rises before the wait period has ended, the cycle is abandoned and the register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | Bus address |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| data_in | input | 16 | Write data from the bus |
| data_out | output | 16 | Read data toward the tri-state pad driver |
| data_oe | output | 1 | Output enable for the tri-state pad driver |
| wait_req | output | 1 | Wait request that stretches the current cycle |

## Verification
On every cycle, the assertions check the following:
- The wait request never runs longer than the configured count.
- The output enable is only ever tied to a read strobe.
- Release of the strobe, or a clash of strobes, returns the controller to idle at the next edge.
- No register is written while a wait is pending.

Other behaviours only the bench scenarios can show:
- Decoding is correct in each window, including I/O ignoring the upper address bits.
- The two spaces alias the same registers.
- Read data matches earlier writes.
- An abandoned cycle, whether from early release or a second strobe, leaves the registers untouched.

// File: rtl/xb_pkg.sv
package xb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STRETCH,
        ST_SERVE,
        ST_HOLD
    } xb_state_e;

    localparam int SEL_MEMR = 0;
    localparam int SEL_MEMW = 1;
    localparam int SEL_IOR  = 2;
    localparam int SEL_IOW  = 3;

endpackage

// File: rtl/xb_decode.sv
module xb_decode
    import xb_pkg::*;
#(
    parameter int                AW       = 24,
    parameter int                IDXW     = 3,
    parameter logic [AW-1:0]     MEM_BASE = 24'h0D0000,
    parameter logic [AW-1:0]     IO_BASE  = 24'h000300
) (
    input  logic [AW-1:0]   addr,
    input  logic [3:0]      strb,
    output logic            hit,
    output logic            is_write,
    output logic [IDXW-1:0] idx
);
    localparam int IOW_BITS = 16;

    logic single;
    logic mem_sel;
    logic mem_match;
    logic io_match;

    always_comb begin
        single    = (strb != 4'b0000) && ((strb & (strb - 4'd1)) == 4'b0000);
        mem_sel   = strb[SEL_MEMR] | strb[SEL_MEMW];
        mem_match = (addr[AW-1:IDXW] == MEM_BASE[AW-1:IDXW]);
        io_match  = (addr[IOW_BITS-1:IDXW] == IO_BASE[IOW_BITS-1:IDXW]);
        hit       = single && (mem_sel ? mem_match : io_match);
        is_write  = strb[SEL_MEMW] | strb[SEL_IOW];
        idx       = addr[IDXW-1:0];
    end

endmodule

// File: rtl/xb_ctrl.sv
module xb_ctrl
    import xb_pkg::*;
#(
    parameter int IDXW  = 3,
    parameter int WAITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      strb,
    input  logic            hit,
    input  logic            is_write,
    input  logic [IDXW-1:0] idx_in,
    output logic            wait_req,
    output logic            data_oe,
    output logic            wr_en,
    output logic [IDXW-1:0] idx_q
);
    localparam logic [1:0] WLOAD = (WAITS > 0) ? 2'(WAITS - 1) : 2'd0;

    xb_state_e state, state_nx;
    logic [3:0] cur_sel;
    logic       wr_q;
    logic [1:0] wcnt;
    logic       held;
    logic       multi;

    always_comb begin
        held  = |(cur_sel & strb);
        multi = ($countones(strb) > 1);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (hit) state_nx = (WAITS == 0) ? ST_SERVE : ST_STRETCH;
            ST_STRETCH: if (!held || multi) state_nx = ST_IDLE;
                        else if (wcnt == 2'd0) state_nx = ST_SERVE;
            ST_SERVE:   if (!held || multi) state_nx = ST_IDLE;
                        else if (wr_q) state_nx = ST_HOLD;
            ST_HOLD:    if (!held || multi) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_sel <= 4'b0000;
            wr_q    <= 1'b0;
            wcnt    <= 2'd0;
            idx_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && hit) begin
                cur_sel <= strb;
                wr_q    <= is_write;
                wcnt    <= WLOAD;
                idx_q   <= idx_in;
            end else if (state == ST_STRETCH && wcnt != 2'd0) begin
                wcnt <= wcnt - 2'd1;
            end
        end
    end

    always_comb begin
        wait_req = (state == ST_STRETCH);
        data_oe  = (state != ST_IDLE) && !wr_q;
        wr_en    = (state == ST_SERVE) && wr_q && held && !multi;
    end

    int wait_run;
    always_ff @(posedge clk) begin
        if (!rst_n)        wait_run <= 0;
        else if (wait_req) wait_run <= wait_run + 1;
        else               wait_run <= 0;
    end

    AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> (wait_run < WAITS)); // R5
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (cur_sel == 4'b0001 || cur_sel == 4'b0100)); // R8
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !held) |=> (!data_oe && !wait_req)); // R7
    AST_MULTI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(strb) > 1) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/xb_regfile.sv
module xb_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && idx == IDXW'(g))
                regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (idx == IDXW'(i)) rdata = regs[i];
    end

endmodule

// File: rtl/expbus_slave.sv
module expbus_slave
    import xb_pkg::*;
#(
    parameter int               ADDR_W   = 24,
    parameter int               DATA_W   = 16,
    parameter int               NREG     = 8,
    parameter int               WAITS    = 2,
    parameter logic [ADDR_W-1:0] MEM_BASE = 24'h0D0000,
    parameter logic [ADDR_W-1:0] IO_BASE  = 24'h000300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              memr_n,
    input  logic              memw_n,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              wait_req
);
    localparam int IDXW = $clog2(NREG);

    logic [3:0]      strb;
    logic            hit;
    logic            is_write;
    logic [IDXW-1:0] idx_dec;
    logic [IDXW-1:0] idx_q;
    logic            wr_en;
    logic [DATA_W-1:0] rdata;

    assign strb = {~iow_n, ~ior_n, ~memw_n, ~memr_n};

    xb_decode #(.AW(ADDR_W), .IDXW(IDXW), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_dec (
        .addr(addr), .strb(strb), .hit(hit), .is_write(is_write), .idx(idx_dec)
    );

    xb_ctrl #(.IDXW(IDXW), .WAITS(WAITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strb(strb), .hit(hit), .is_write(is_write),
        .idx_in(idx_dec), .wait_req(wait_req), .data_oe(data_oe), .wr_en(wr_en), .idx_q(idx_q)
    );

    xb_regfile #(.NREG(NREG), .DW(DATA_W), .IDXW(IDXW)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx_q), .wdata(data_in), .rdata(rdata)
    );

    assign data_out = data_oe ? rdata : '0;

    AST_WR_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wait_req); // R6

endmodule

// File: tb/sim_expbus_slave.sv
`timescale 1ns/1ps
module sim_expbus_slave;
    localparam int          WAITS    = 2;
    localparam logic [23:0] MEM_BASE = 24'h0D0000;
    localparam logic [23:0] IO_BASE  = 24'h000300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic [3:0]  strb = 4'b0000;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        data_oe;
    logic        wait_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] shadow [8];

    always #2.5 clk = ~clk;

    expbus_slave #(.WAITS(WAITS), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .memr_n(~strb[0]), .memw_n(~strb[1]), .ior_n(~strb[2]), .iow_n(~strb[3]),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .wait_req(wait_req)
    );

    function automatic bit exp_hit(int sel, logic [23:0] a);
        if (sel < 2) return a[23:3] == MEM_BASE[23:3];
        return a[15:3] == IO_BASE[15:3];
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one complete bus cycle on strobe 'sel' (0 memr,1 memw,2 ior,3 iow)
    task automatic bus_cycle(int sel, logic [23:0] a, logic [15:0] wd);
        bit h, rd;
        h  = exp_hit(sel, a);
        rd = (sel == 0 || sel == 2);
        @(negedge clk);
        addr = a; data_in = wd; strb = 4'b0001 << sel;
        for (int k = 1; k <= WAITS + 2; k++) begin
            @(negedge clk);
            chk("R5 wait_req", {15'd0, wait_req}, {15'd0, h && (k <= WAITS)});
            chk(rd ? "R7 data_oe" : "R8 data_oe", {15'd0, data_oe}, {15'd0, h && rd});
            if (k == WAITS + 1 && h && rd)
                chk(sel == 0 ? "R2 read data" : "R3 R4 read data", data_out, shadow[a[2:0]]);
            if (!(h && rd)) chk("R8 data_out idle", data_out, 16'h0);
        end
        strb = 4'b0000;
        if (h && !rd) shadow[a[2:0]] = wd;
        @(negedge clk);
        chk("R7 oe released", {15'd0, data_oe}, 16'h0);
    endtask

    task automatic readback(int idx, string tag);
        bus_cycle(0, MEM_BASE | 24'(idx), 16'h0);
        checks++;
        if (shadow[idx] === 16'hxxxx) begin failures++; $display("FAIL %s shadow", tag); end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) shadow[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wait_req reset", {15'd0, wait_req}, 16'h0);
        chk("R1 data_oe reset", {15'd0, data_oe}, 16'h0);
        for (int i = 0; i < 8; i++) bus_cycle(0, MEM_BASE | 24'(i), 16'h0);   // R1 all zero

        // R2 memory write, R4 read back through I/O with upper bits set (R3)
        bus_cycle(1, MEM_BASE | 24'd5, 16'hBEEF);
        bus_cycle(2, 24'hA50000 | IO_BASE | 24'd5, 16'h0);
        bus_cycle(3, IO_BASE | 24'd2, 16'h1234);
        bus_cycle(0, MEM_BASE | 24'd2, 16'h0);
        // misses just outside each window
        bus_cycle(1, MEM_BASE + 24'd8, 16'hDEAD);
        bus_cycle(3, IO_BASE - 24'd1, 16'hDEAD);
        bus_cycle(0, MEM_BASE | 24'd7, 16'h0);

        // R9 two strobes together: ignored
        @(negedge clk);
        addr = MEM_BASE | 24'd5; data_in = 16'h5555; strb = 4'b1010;
        repeat (WAITS + 2) begin
            @(negedge clk);
            chk("R9 multi wait", {15'd0, wait_req}, 16'h0);
            chk("R9 multi oe", {15'd0, data_oe}, 16'h0);
        end
        strb = 4'b0000;
        bus_cycle(0, MEM_BASE | 24'd5, 16'h0);

        // R9 second strobe appears mid-cycle
        @(negedge clk);
        addr = MEM_BASE | 24'd5; data_in = 16'h6666; strb = 4'b0010;
        @(negedge clk);
        strb = 4'b0110;
        @(negedge clk);
        chk("R9 abort wait", {15'd0, wait_req}, 16'h0);
        strb = 4'b0000;
        bus_cycle(2, IO_BASE | 24'd5, 16'h0);

        // R10 early release during wait
        @(negedge clk);
        addr = IO_BASE | 24'd5; data_in = 16'h7777; strb = 4'b1000;
        @(negedge clk);
        chk("R10 in wait", {15'd0, wait_req}, 16'h1);
        strb = 4'b0000;
        @(negedge clk);
        chk("R10 wait dropped", {15'd0, wait_req}, 16'h0);
        bus_cycle(0, MEM_BASE | 24'd5, 16'h0);

        // random traffic
        for (int n = 0; n < 80; n++) begin
            int sel;
            logic [23:0] a;
            sel = int'($urandom % 4);
            v = 16'($urandom);
            if ($urandom % 4 != 0)
                a = (sel < 2) ? (MEM_BASE | 24'($urandom % 8))
                              : ({8'($urandom), IO_BASE[15:0]} | 24'($urandom % 8));
            else
                a = 24'($urandom);
            bus_cycle(sel, a, v);   // R2 R3 R4 R5 R6 R7 R8
        end
        for (int i = 0; i < 8; i++) bus_cycle(2, IO_BASE | 24'(i), 16'h0);  // R6 final contents

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule